// File: doc/BRIEF.md
# Two-Level Saturating-Counter Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating up/down counters. A counter learns the bias of the branches that map onto it. The counter used for a branch is picked by recent branch outcomes combined with some bits of the branch address. Outcome history lives in two places: one shared (global) shift register, and a small table of per-address shift registers selected by address bits.

A front end presents a branch address on the lookup port and gets a taken/not-taken guess back in the same cycle. When the branch resolves, the back end presents its address and real outcome on the update port. That update trains one counter and shifts the outcome into the history registers. A mode input picks how the table index is formed:
- global history joined with address bits,
- per-address history joined with address bits,
- address bits XORed with global history.

No tags are stored, so unrelated branches may share a counter. Reset is taken asynchronously (active low) and released through a two-flop synchronizer.

Top module: `bpred2lvl`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 1 and every history register is zero, so any lookup predicts not-taken (`lk_taken`=0).
- R2: `lk_taken` is 1 exactly when the indexed 2-bit counter holds 2 or 3.
- R3: An update with `upd_taken`=1 increments the indexed counter, which stays at 3 once it is there.
- R4: An update with `upd_taken`=0 decrements the indexed counter, which stays at 0 once it is there.
- R5: In mode 0 the 6-bit table index is {global history[3:0], pc[3:2]}.
- R6: In mode 1 the index is {local history[3:0], pc[3:2]}, where the local history register is chosen from 8 by pc[4:2].
- R7: In mode 2 the index is pc[7:2] XOR {2'b00, global history[3:0]}.
- R8: Every update shifts the outcome (1 = taken) into bit 0 of the global history and of the local history register chosen by `upd_pc`[4:2]. The oldest bit is dropped.
- R9: A lookup in the same cycle as an update sees the counters and histories as they were before that update.
- R10: With `upd_en`=0, no counter or history changes.
- R11: Mode 3 forms the index exactly as mode 0 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Index mode: 0 global, 1 per-address, 2 XOR, 3 as 0 |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction, 1 = taken |
| upd_en | input | 1 | Update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Embedded properties check on every cycle that:
- a counter moves by exactly one step in the direction of the outcome, or holds at its limit;
- the global history shifts in the outcome;
- counters and history hold still when no update is strobed.

Index formation for each mode, the reset contents, the pre-update view seen by a same-cycle lookup, and aliasing between addresses can only be shown through the prediction output. These are covered by directed and random scenarios. In those scenarios, a behavioural model of the counters and histories predicts `lk_taken` for every cycle.

// File: rtl/bp2_pkg.sv
package bp2_pkg;
  typedef enum logic [1:0] {
    HM_GLOBAL = 2'd0,
    HM_LOCAL  = 2'd1,
    HM_XOR    = 2'd2,
    HM_ALT    = 2'd3
  } hmode_e;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int K      = 4,
  parameter int A      = 3,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] lk_pc,
  output logic [K-1:0]    g_hist,
  output logic [K-1:0]    lk_lhist,
  output logic [K-1:0]    up_lhist
);
  localparam int LH = 1 << A;

  logic [K-1:0] g_q, g_d;
  logic [K-1:0] lh_q [LH];
  logic [K-1:0] lh_d [LH];
  logic [A-1:0] up_sel, lk_sel;

  assign up_sel   = upd_pc[PC_LSB +: A];
  assign lk_sel   = lk_pc[PC_LSB +: A];
  assign g_hist   = g_q;
  assign lk_lhist = lh_q[lk_sel];
  assign up_lhist = lh_q[up_sel];

  always_comb begin
    g_d = g_q;
    for (int i = 0; i < LH; i++) lh_d[i] = lh_q[i];
    if (upd_en) begin
      g_d          = {g_q[K-2:0], upd_taken};
      lh_d[up_sel] = {lh_q[up_sel][K-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q <= '0;
      for (int i = 0; i < LH; i++) lh_q[i] <= '0;
    end else begin
      g_q <= g_d;
      for (int i = 0; i < LH; i++) lh_q[i] <= lh_d[i];
    end
  end

  // R8
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (g_q[0] == $past(upd_taken)) && (g_q[K-1:1] == $past(g_q[K-2:0])));
  // R8
  lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> lh_q[$past(up_sel)][0] == $past(upd_taken));
  // R10
  ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(g_q));
endmodule

// File: rtl/bp_index.sv
module bp_index
  import bp2_pkg::*;
#(
  parameter int K      = 4,
  parameter int M      = 2,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic [1:0]      mode,
  input  logic [PC_W-1:0] pc,
  input  logic [K-1:0]    ghist,
  input  logic [K-1:0]    lhist,
  output logic [K+M-1:0]  idx
);
  localparam int IW = K + M;

  hmode_e       m;
  logic [M-1:0] pcb;
  logic [IW-1:0] pcw;

  assign m   = hmode_e'(mode);
  assign pcb = pc[PC_LSB +: M];
  assign pcw = pc[PC_LSB +: IW];

  always_comb begin
    unique case (m)
      HM_LOCAL: idx = {lhist, pcb};
      HM_XOR:   idx = pcw ^ IW'(ghist);
      default:  idx = {ghist, pcb};
    endcase
  end
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int IW = 6,
  parameter int N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_taken
);
  localparam int          ENT  = 1 << IW;
  localparam logic [N-1:0] CMAX = '1;
  localparam logic [N-1:0] CMIN = '0;
  localparam logic [N-1:0] CRST = N'((1 << (N - 1)) - 1);

  logic [N-1:0] cnt_q [ENT];
  logic [N-1:0] cnt_d [ENT];
  logic [N-1:0] cur;

  assign cur      = cnt_q[upd_idx];
  assign rd_taken = cnt_q[rd_idx][N-1];

  always_comb begin
    for (int i = 0; i < ENT; i++) cnt_d[i] = cnt_q[i];
    if (upd_en) begin
      if (upd_taken && cur != CMAX)       cnt_d[upd_idx] = cur + 1'b1;
      else if (!upd_taken && cur != CMIN) cnt_d[upd_idx] = cur - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) cnt_q[i] <= CRST;
    end else begin
      for (int i = 0; i < ENT; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  // R3
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && cur != CMAX) |=> cnt_q[$past(upd_idx)] == N'($past(cur) + 1'b1));
  // R3
  cnt_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && cur == CMAX) |=> cnt_q[$past(upd_idx)] == CMAX);
  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && cur != CMIN) |=> cnt_q[$past(upd_idx)] == N'($past(cur) - 1'b1));
  // R4
  cnt_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && cur == CMIN) |=> cnt_q[$past(upd_idx)] == CMIN);
  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> cnt_q[$past(rd_idx)] == $past(cnt_q[rd_idx]));
endmodule

// File: rtl/bpred2lvl.sv
module bpred2lvl #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int K      = 4,
  parameter int M      = 2,
  parameter int A      = 3,
  parameter int N      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IW = K + M;

  logic          srst_n;
  logic [K-1:0]  ghist, lk_lh, up_lh;
  logic [IW-1:0] lk_idx, up_idx;

  bp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  bp_hist #(.K(K), .A(A), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_hist (
    .clk(clk), .rst_n(srst_n), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .lk_pc(lk_pc), .g_hist(ghist),
    .lk_lhist(lk_lh), .up_lhist(up_lh)
  );

  bp_index #(.K(K), .M(M), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_lk_idx (
    .mode(mode), .pc(lk_pc), .ghist(ghist), .lhist(lk_lh), .idx(lk_idx)
  );

  bp_index #(.K(K), .M(M), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_up_idx (
    .mode(mode), .pc(upd_pc), .ghist(ghist), .lhist(up_lh), .idx(up_idx)
  );

  bp_pht #(.IW(IW), .N(N)) u_pht (
    .clk(clk), .rst_n(srst_n), .rd_idx(lk_idx), .rd_taken(lk_taken),
    .upd_en(upd_en), .upd_idx(up_idx), .upd_taken(upd_taken)
  );
endmodule

// File: tb/sim_bpred2lvl.sv
module sim_bpred2lvl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [31:0] lk_pc, upd_pc;
  logic        lk_taken, upd_en, upd_taken;

  int n_chk = 0, n_fail = 0;
  int pht [64];
  int gh;
  int lh [8];

  always #2 clk = ~clk;

  bpred2lvl u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  function automatic int mdl_idx(input int md, input logic [31:0] pc);
    int h;
    h = (md == 1) ? lh[pc[4:2]] : gh;
    if (md == 2) return int'(pc[7:2]) ^ h;
    return (h << 2) | int'(pc[3:2]);
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 64; i++) pht[i] = 1;
    for (int i = 0; i < 8; i++) lh[i] = 0;
    gh = 0;
  endtask

  task automatic mdl_update(input int md, input logic [31:0] pc, input logic t);
    int ix;
    ix = mdl_idx(md, pc);
    if (t && pht[ix] < 3) pht[ix]++;
    if (!t && pht[ix] > 0) pht[ix]--;
    gh = ((gh << 1) | int'(t)) & 15;
    lh[pc[4:2]] = ((lh[pc[4:2]] << 1) | int'(t)) & 15;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lk_taken actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before the posedge, advance model at it
  task automatic step(input string tag, input int md, input logic [31:0] lpc,
                      input logic ue, input logic [31:0] upc, input logic ut);
    logic exp;
    mode = 2'(md); lk_pc = lpc; upd_en = ue; upd_pc = upc; upd_taken = ut;
    #1;
    exp = (pht[mdl_idx(md, lpc)] >= 2);
    check(tag, lk_taken, exp);
    @(posedge clk);
    if (ue) mdl_update(md, upc, ut);
    @(negedge clk);
  endtask

  logic [31:0] pcs [8];

  initial begin
    pcs[0] = 32'h0;   pcs[1] = 32'h4;  pcs[2] = 32'h8;  pcs[3] = 32'h14;
    pcs[4] = 32'h1c;  pcs[5] = 32'h40; pcs[6] = 32'h9c; pcs[7] = 32'h100;
    rst_n = 1'b0; mode = 0; lk_pc = 0; upd_en = 0; upd_pc = 0; upd_taken = 0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: every address predicts not-taken after reset, in every mode
    for (int md = 0; md < 4; md++)
      for (int p = 0; p < 8; p++) begin
        #1; mode = 2'(md); lk_pc = pcs[p]; #1;
        check("R1 reset", lk_taken, 1'b0);
      end
    @(negedge clk);

    // R3 R2 R5: train one branch taken in global mode until history and counter saturate
    for (int i = 0; i < 10; i++) step("R3 R5 taken training", 0, 32'h8, 1, 32'h8, 1);
    step("R2 taken predicted", 0, 32'h8, 0, 0, 0);
    check("R3 saturated high", lk_taken, 1'b1);
    // R11: mode 3 uses the same entry
    step("R11 alt mode", 3, 32'h8, 0, 0, 0);
    check("R11 alt mode same entry", lk_taken, 1'b1);

    // R9: same-cycle lookup sees pre-update state
    step("R9 same cycle", 0, 32'h8, 1, 32'h8, 0);
    step("R9 after update", 0, 32'h8, 0, 0, 0);

    // R4: not-taken training saturates low
    for (int i = 0; i < 10; i++) step("R4 not-taken training", 0, 32'h8, 1, 32'h8, 0);
    step("R4 saturated low", 0, 32'h8, 0, 0, 0);

    // R10: idle cycles leave predictions unchanged
    for (int p = 0; p < 8; p++) step("R10 idle", p % 3, pcs[p], 0, pcs[p], 1);

    // R6 R8: per-address histories diverge between two branches
    for (int i = 0; i < 6; i++) begin
      step("R6 R8 local a", 1, 32'h14, 1, 32'h14, 1);
      step("R6 R8 local b", 1, 32'h1c, 1, 32'h1c, 0);
    end

    // R7: XOR mode with alternating outcome
    for (int i = 0; i < 12; i++) step("R7 xor", 2, 32'h9c, 1, 32'h9c, 1'(i % 2));

    // random mix across all modes
    for (int i = 0; i < 4000; i++) begin
      int md;
      logic [31:0] lp, up;
      md = int'($urandom_range(0, 3));
      lp = (i % 5 == 0) ? $urandom : pcs[$urandom_range(0, 7)];
      up = (i % 7 == 0) ? $urandom : pcs[$urandom_range(0, 7)];
      step("R2 R5 R6 R7 R8 R9 random", md, lp, 1'($urandom_range(0, 3) != 0), up,
           1'($urandom_range(0, 2) != 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule